// File: doc/BRIEF.md
# Unified TLB Translator with Variable Pages and Protection

This block turns a 32-bit virtual data address into a physical address. It searches a fully associative table of translation entries in parallel, and each entry can map a page of 1 KB, 4 KB, 64 KB or 1 MB. A match may depend on the address-space identifier. The matching entry's protection field is then checked against the access direction and the privilege level. A write to a clean page raises a first-write fault.

Two fixed windows of the address space skip the table. A global enable can also switch translation off. A replacement counter chooses the slot that the next load overwrites. The counter advances on every access that reaches the table and wraps at a programmable boundary.

An access is offered by pulsing `acc_valid` with its address, direction and mode. The result appears on registered outputs one cycle later and stays until the next access.

Top module: `utlb_xlate`

## Requirements
- R1: After reset `res_valid` is 0, `repl_idx` is 0 and every table slot is invalid, so the first translated access misses.
- R2: Entry size code 0/1/2/3 selects a 1 KB/4 KB/64 KB/1 MB page. The match base is `vpn<<10` with the in-page bits cleared. The physical address is `(ppn<<10)` with the in-page bits cleared, ORed with the in-page bits of the virtual address.
- R3: The ASID is compared only when `single_vspace` is 0 or `acc_priv` is 0. An entry whose share bit is set never compares its ASID.
- R4: An entry loaded with its valid bit clear never matches. A miss reports fault code 1, exception 0x040 on a read and 0x060 on a write, with `res_hit` 0.
- R5: When two or more entries match, the result is fault code 2 with exception 0x140 and `res_hit` 0.
- R6: Access rights come from {prot, priv}:
  - 000 and 010 forbid any access.
  - 001, 100 and 101 allow reads only.
  - 011, 110 and 111 allow reads and writes.
  - A forbidden access is fault code 3, with 0x0A0 on a read and 0x0C0 on a write; `res_hit` is 1 and `res_paddr` is 0.
- R7: A permitted write to an entry with the dirty bit clear is fault code 4 with exception 0x080. A read of the same entry succeeds.
- R8: Addresses 0x80000000–0xBFFFFFFF skip the table and keep only their low 29 bits. Addresses at or above 0xE0000000 skip it unchanged. Neither window moves the replacement counter.
- R9: With `xlate_en` 0, an address outside those windows keeps its low 29 bits, with no fault and no counter step.
- R10: In user mode (`acc_priv`=0), an address in either window outside 0xE0000000–0xE4000000 is fault code 5, exception 0x0E0 on a read and 0x100 on a write.
- R11: Each access that reaches the table steps `repl_idx` by one. The counter goes to 0 instead when the next value would exceed a nonzero `repl_limit`, or would exceed ENTRIES-1.
- R12: A load writes the whole entry into the slot named by `repl_idx` in one cycle and does not move the counter.
- R13: `res_valid` is high for exactly the cycle after each `acc_valid` cycle. Fault code 0 means success, with exception 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access strobe |
| acc_vaddr | input | 32 | Virtual address |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_priv | input | 1 | 1 = privileged mode |
| cur_asid | input | 8 | Current address-space identifier |
| xlate_en | input | 1 | Translation enable |
| single_vspace | input | 1 | Single-virtual-space mode |
| repl_limit | input | 6 | Replacement wrap boundary, 0 = full range |
| ld_valid | input | 1 | Load strobe |
| ld_vpn | input | 22 | Virtual page number |
| ld_asid | input | 8 | Entry ASID |
| ld_ppn | input | 22 | Physical page number |
| ld_size | input | 2 | Page size code |
| ld_prot | input | 2 | Protection code |
| ld_dirty | input | 1 | Dirty bit |
| ld_share | input | 1 | Shared-page bit |
| ld_entry_valid | input | 1 | Entry valid bit |
| res_valid | output | 1 | Result strobe |
| res_paddr | output | 32 | Physical address (0 on fault) |
| res_hit | output | 1 | Exactly one entry matched |
| res_fault | output | 3 | Fault code (0 none, 1 miss, 2 multi, 3 prot, 4 first write, 5 address) |
| res_excode | output | 12 | Exception code |
| repl_idx | output | 6 | Replacement counter |

## Verification
The assertions assume two things about the inputs: a load and an access are never offered in the same cycle, and the window addresses are decoded only from `acc_vaddr` while `acc_valid` is high. The directed tasks follow both rules. Each load is separated from the next by a translated miss access, so every entry lands in its own slot. Overlapping entries are created only in the test that is meant to provoke a multiple hit.

// File: rtl/utlb_pkg.sv
// Shared types and helpers for the unified TLB translator.
// Assumes a 32-bit virtual space with a 1 KB minimum page.
package utlb_pkg;
    localparam int VA_W   = 32;
    localparam int PG_LSB = 10;
    localparam int VPN_W  = VA_W - PG_LSB;
    localparam int ASID_W = 8;
    localparam int EXC_W  = 12;

    typedef enum logic [2:0] {
        FLT_NONE    = 3'd0,
        FLT_MISS    = 3'd1,
        FLT_MULTI   = 3'd2,
        FLT_PROT    = 3'd3,
        FLT_FIRSTWR = 3'd4,
        FLT_ADDR    = 3'd5
    } fault_e;

    localparam logic [EXC_W-1:0] EXC_MISS_RD  = 12'h040;
    localparam logic [EXC_W-1:0] EXC_MISS_WR  = 12'h060;
    localparam logic [EXC_W-1:0] EXC_FIRSTWR  = 12'h080;
    localparam logic [EXC_W-1:0] EXC_PROT_RD  = 12'h0A0;
    localparam logic [EXC_W-1:0] EXC_PROT_WR  = 12'h0C0;
    localparam logic [EXC_W-1:0] EXC_ADDR_RD  = 12'h0E0;
    localparam logic [EXC_W-1:0] EXC_ADDR_WR  = 12'h100;
    localparam logic [EXC_W-1:0] EXC_MULTI    = 12'h140;

    typedef struct packed {
        logic              valid;
        logic              share;
        logic              dirty;
        logic [1:0]        size;
        logic [1:0]        prot;
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vpn;
        logic [VPN_W-1:0]  ppn;
    } tlb_entry_t;

    // In-page offset mask for a size code.
    function automatic logic [VA_W-1:0] offs_mask(input logic [1:0] sz);
        case (sz)
            2'b00:   return 32'h0000_03FF;
            2'b01:   return 32'h0000_0FFF;
            2'b10:   return 32'h0000_FFFF;
            default: return 32'h000F_FFFF;
        endcase
    endfunction
endpackage

// File: rtl/utlb_repl.sv
// Replacement counter: steps on each table access, wraps at a nonzero
// software boundary or at ENTRIES-1. Assumes limit < ENTRIES.
module utlb_repl #(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [IDX_W-1:0] limit,
    output logic [IDX_W-1:0] idx
);
    logic [IDX_W:0] nxt;
    logic           wrap;

    // Candidate next value and wrap decision.
    always_comb begin
        nxt  = {1'b0, idx} + 1'b1;
        wrap = ((limit != '0) && (nxt > {1'b0, limit})) ||
               (nxt > (IDX_W+1)'(ENTRIES - 1));
    end

    // Counter register.
    always_ff @(posedge clk) begin
        if (!rst_n)    idx <= '0;
        else if (step) idx <= wrap ? '0 : nxt[IDX_W-1:0];
    end

    // R11
    step_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (idx == '0 || idx == $past(idx) + 1'b1));
    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(idx));
endmodule

// File: rtl/utlb_perm.sv
// Protection and dirty check for a single matched entry.
// Purely combinational; assumes its inputs come from a valid hit.
module utlb_perm (
    input  logic [1:0] prot,
    input  logic       priv,
    input  logic       write,
    input  logic       dirty,
    output logic       viol,
    output logic       first_wr
);
    logic rd_ok, wr_ok;

    // Rights table indexed by protection code and mode.
    always_comb begin
        case ({prot, priv})
            3'b000, 3'b010:         begin rd_ok = 1'b0; wr_ok = 1'b0; end
            3'b001, 3'b100, 3'b101: begin rd_ok = 1'b1; wr_ok = 1'b0; end
            default:                begin rd_ok = 1'b1; wr_ok = 1'b1; end
        endcase
        viol     = write ? !wr_ok : !rd_ok;
        first_wr = write && wr_ok && !dirty;
    end

    // R6
    always_comb begin
        if (prot == 2'b11) begin
            full_rights_chk: assert (!viol);
        end
    end
endmodule

// File: rtl/utlb_cam.sv
// Entry store and parallel match. A load writes one slot whole; each
// slot compares the address under its own page mask. Assumes ld_idx < ENTRIES.
module utlb_cam
    import utlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [IDX_W-1:0]  ld_idx,
    input  tlb_entry_t        ld_entry,
    input  logic [VA_W-1:0]   vaddr,
    input  logic [ASID_W-1:0] asid,
    input  logic              chk_asid,
    output logic              hit_any,
    output logic              hit_multi,
    output logic [VPN_W-1:0]  sel_ppn,
    output logic [1:0]        sel_size,
    output logic [1:0]        sel_prot,
    output logic              sel_dirty
);
    tlb_entry_t         tbl_q [ENTRIES];
    logic [ENTRIES-1:0] hit_vec;

    // Entry storage: cleared on reset, one slot written per load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) tbl_q[i] <= '0;
        end else if (ld_en) begin
            tbl_q[ld_idx] <= ld_entry;
        end
    end

    // Per-slot comparator.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        logic [VA_W-1:0] pmask;
        logic            asid_ok;
        assign pmask   = ~offs_mask(tbl_q[g].size);
        assign asid_ok = tbl_q[g].share || !chk_asid || (tbl_q[g].asid == asid);
        assign hit_vec[g] = tbl_q[g].valid && asid_ok &&
                            ((vaddr & pmask) == ({tbl_q[g].vpn, {PG_LSB{1'b0}}} & pmask));
    end

    // Hit summary and field selection (meaningful for a single hit).
    always_comb begin
        hit_any   = |hit_vec;
        hit_multi = |(hit_vec & (hit_vec - 1'b1));
        sel_ppn   = '0;
        sel_size  = '0;
        sel_prot  = '0;
        sel_dirty = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) begin
                sel_ppn   = sel_ppn   | tbl_q[i].ppn;
                sel_size  = sel_size  | tbl_q[i].size;
                sel_prot  = sel_prot  | tbl_q[i].prot;
                sel_dirty = sel_dirty | tbl_q[i].dirty;
            end
        end
    end

    // R5
    multi_implies_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_multi |-> hit_any);
endmodule

// File: rtl/utlb_xlate.sv
// Top of the unified TLB translator. Decodes the fixed windows, drives the
// match array, prioritises faults and registers the result one cycle after
// acc_valid. Assumes loads and accesses are not offered in the same cycle.
module utlb_xlate
    import utlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [31:0]       acc_vaddr,
    input  logic              acc_write,
    input  logic              acc_priv,
    input  logic [7:0]        cur_asid,
    input  logic              xlate_en,
    input  logic              single_vspace,
    input  logic [IDX_W-1:0]  repl_limit,
    input  logic              ld_valid,
    input  logic [21:0]       ld_vpn,
    input  logic [7:0]        ld_asid,
    input  logic [21:0]       ld_ppn,
    input  logic [1:0]        ld_size,
    input  logic [1:0]        ld_prot,
    input  logic              ld_dirty,
    input  logic              ld_share,
    input  logic              ld_entry_valid,
    output logic              res_valid,
    output logic [31:0]       res_paddr,
    output logic              res_hit,
    output logic [2:0]        res_fault,
    output logic [11:0]       res_excode,
    output logic [IDX_W-1:0]  repl_idx
);
    tlb_entry_t       ld_entry;
    logic             hit_any, hit_multi, sel_dirty, viol, first_wr;
    logic [VPN_W-1:0] sel_ppn;
    logic [1:0]       sel_size, sel_prot;
    logic             in_p12, in_fixed, user_ok, use_tlb, chk_asid, step;
    logic [VA_W-1:0]  omask, pa_c;
    logic             hit_c;
    fault_e           flt_c;
    logic [EXC_W-1:0] exc_c;

    // Pack the load port into one entry.
    always_comb begin
        ld_entry = '{valid: ld_entry_valid, share: ld_share, dirty: ld_dirty,
                     size: ld_size, prot: ld_prot, asid: ld_asid,
                     vpn: ld_vpn, ppn: ld_ppn};
    end

    // Window decode and table qualification.
    always_comb begin
        in_p12   = (acc_vaddr[31:30] == 2'b10);
        in_fixed = in_p12 || (acc_vaddr[31:29] == 3'b111);
        user_ok  = (acc_vaddr >= 32'hE000_0000) && (acc_vaddr <= 32'hE400_0000);
        use_tlb  = !in_fixed && xlate_en;
        chk_asid = !single_vspace || !acc_priv;
        step     = acc_valid && use_tlb;
    end

    utlb_repl #(.ENTRIES(ENTRIES)) u_repl (
        .clk(clk), .rst_n(rst_n), .step(step), .limit(repl_limit), .idx(repl_idx)
    );

    utlb_cam #(.ENTRIES(ENTRIES)) u_cam (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_valid), .ld_idx(repl_idx),
        .ld_entry(ld_entry), .vaddr(acc_vaddr), .asid(cur_asid),
        .chk_asid(chk_asid), .hit_any(hit_any), .hit_multi(hit_multi),
        .sel_ppn(sel_ppn), .sel_size(sel_size), .sel_prot(sel_prot),
        .sel_dirty(sel_dirty)
    );

    utlb_perm u_perm (
        .prot(sel_prot), .priv(acc_priv), .write(acc_write),
        .dirty(sel_dirty), .viol(viol), .first_wr(first_wr)
    );

    // Result selection: windows, disabled translation, then multi > miss > prot > first write.
    always_comb begin
        omask = offs_mask(sel_size);
        pa_c  = '0;
        hit_c = 1'b0;
        flt_c = FLT_NONE;
        exc_c = '0;
        if (in_fixed) begin
            if (!acc_priv && !user_ok) begin
                flt_c = FLT_ADDR;
                exc_c = acc_write ? EXC_ADDR_WR : EXC_ADDR_RD;
            end else begin
                pa_c = in_p12 ? {3'b000, acc_vaddr[28:0]} : acc_vaddr;
            end
        end else if (!xlate_en) begin
            pa_c = {3'b000, acc_vaddr[28:0]};
        end else if (hit_multi) begin
            flt_c = FLT_MULTI;
            exc_c = EXC_MULTI;
        end else if (!hit_any) begin
            flt_c = FLT_MISS;
            exc_c = acc_write ? EXC_MISS_WR : EXC_MISS_RD;
        end else begin
            hit_c = 1'b1;
            if (viol) begin
                flt_c = FLT_PROT;
                exc_c = acc_write ? EXC_PROT_WR : EXC_PROT_RD;
            end else if (first_wr) begin
                flt_c = FLT_FIRSTWR;
                exc_c = EXC_FIRSTWR;
            end else begin
                pa_c = ({sel_ppn, {PG_LSB{1'b0}}} & ~omask) | (acc_vaddr & omask);
            end
        end
    end

    // Result registers, updated on each access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            res_paddr  <= '0;
            res_hit    <= 1'b0;
            res_fault  <= FLT_NONE;
            res_excode <= '0;
        end else begin
            res_valid <= acc_valid;
            if (acc_valid) begin
                res_paddr  <= pa_c;
                res_hit    <= hit_c;
                res_fault  <= flt_c;
                res_excode <= exc_c;
            end
        end
    end

    // R13
    res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> res_valid);
    // R13
    res_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !res_valid);
    // R8
    window_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_vaddr[31:30] == 2'b10) |=> $stable(repl_idx));
    // R12
    load_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && !acc_valid) |=> $stable(repl_idx));
    // R13
    code_pairing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ((res_fault == FLT_NONE) == (res_excode == '0)));
endmodule

// File: tb/sim_utlb_xlate.sv
`timescale 1ns/1ps
module sim_utlb_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_vaddr = '0;
    logic        acc_write = 1'b0;
    logic        acc_priv = 1'b1;
    logic [7:0]  cur_asid = '0;
    logic        xlate_en = 1'b1;
    logic        single_vspace = 1'b0;
    logic [5:0]  repl_limit = '0;
    logic        ld_valid = 1'b0;
    logic [21:0] ld_vpn = '0;
    logic [7:0]  ld_asid = '0;
    logic [21:0] ld_ppn = '0;
    logic [1:0]  ld_size = '0;
    logic [1:0]  ld_prot = '0;
    logic        ld_dirty = 1'b0;
    logic        ld_share = 1'b0;
    logic        ld_entry_valid = 1'b0;
    logic        res_valid;
    logic [31:0] res_paddr;
    logic        res_hit;
    logic [2:0]  res_fault;
    logic [11:0] res_excode;
    logic [5:0]  repl_idx;

    int n_chk = 0;
    int n_bad = 0;
    int exp_idx = 0;

    localparam logic [2:0] F_NONE = 3'd0, F_MISS = 3'd1, F_MULTI = 3'd2,
                           F_PROT = 3'd3, F_FWR = 3'd4, F_ADDR = 3'd5;

    always #2.5 clk = ~clk;

    utlb_xlate u0 (.*);

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_step();
        int nx = exp_idx + 1;
        if ((repl_limit != 0 && nx > repl_limit) || nx > 63) exp_idx = 0;
        else exp_idx = nx;
    endtask

    task automatic do_acc(input logic [31:0] va, input logic wr, input logic pv,
                          input logic [2:0] ef, input logic [11:0] ec, input logic eh,
                          input logic [31:0] epa, input bit tlb, input string tag);
        @(negedge clk);
        acc_vaddr = va; acc_write = wr; acc_priv = pv; acc_valid = 1'b1;
        @(negedge clk);
        acc_valid = 1'b0;
        if (tlb) model_step();
        check(tag, {7'd0, res_valid, ef == res_fault, res_fault, res_excode, res_hit, res_paddr, repl_idx},
                   {7'd0, 1'b1, 1'b1, ef, ec, eh, epa, 6'(exp_idx)});
    endtask

    task automatic bump(input string tag);
        do_acc(32'h0F00_0000, 1'b0, 1'b1, F_MISS, 12'h040, 1'b0, 32'h0, 1'b1, tag);
    endtask

    task automatic do_load(input logic [31:0] va, input logic [7:0] asid, input logic [21:0] ppn,
                           input logic [1:0] sz, input logic [1:0] pr, input logic dty,
                           input logic shr, input logic v);
        @(negedge clk);
        ld_vpn = va[31:10]; ld_asid = asid; ld_ppn = ppn; ld_size = sz;
        ld_prot = pr; ld_dirty = dty; ld_share = shr; ld_entry_valid = v; ld_valid = 1'b1;
        @(negedge clk);
        ld_valid = 1'b0;
        check("R12 load keeps counter", 64'(repl_idx), 64'(exp_idx));
        bump("R4 separating miss");
    endtask

    task automatic t_reset();
        check("R1 reset res_valid", 64'(res_valid), 64'd0);
        check("R1 reset repl_idx", 64'(repl_idx), 64'd0);
        do_acc(32'h0000_1000, 1'b0, 1'b1, F_MISS, 12'h040, 1'b0, 0, 1'b1, "R1 empty table read miss");
        do_acc(32'h0000_1000, 1'b1, 1'b1, F_MISS, 12'h060, 1'b0, 0, 1'b1, "R4 write miss");
    endtask

    task automatic t_basic();
        do_load(32'h0040_0000, 8'h00, 22'h2000, 2'b01, 2'b11, 1'b1, 1'b1, 1'b1);
        do_acc(32'h0040_0ABC, 1'b0, 1'b1, F_NONE, 0, 1'b1, 32'h0080_0ABC, 1'b1, "R2 4K read hit");
        @(negedge clk);
        check("R13 res_valid single pulse", 64'(res_valid), 64'd0);
    endtask

    task automatic t_sizes();
        do_load(32'h0100_0000, 8'h00, 22'h0100, 2'b00, 2'b11, 1'b1, 1'b1, 1'b1);
        do_acc(32'h0100_03FF, 1'b0, 1'b1, F_NONE, 0, 1'b1, 32'h0004_03FF, 1'b1, "R2 1K top byte");
        do_acc(32'h0100_0400, 1'b0, 1'b1, F_MISS, 12'h040, 1'b0, 0, 1'b1, "R2 1K next page misses");
        do_load(32'h0200_0000, 8'h00, 22'h0400, 2'b10, 2'b11, 1'b1, 1'b1, 1'b1);
        do_acc(32'h0200_FFF0, 1'b0, 1'b1, F_NONE, 0, 1'b1, 32'h0010_FFF0, 1'b1, "R2 64K hit");
        do_load(32'h0301_2345, 8'h00, 22'h1003, 2'b11, 2'b11, 1'b1, 1'b1, 1'b1);
        do_acc(32'h030A_BCDE, 1'b0, 1'b1, F_NONE, 0, 1'b1, 32'h004A_BCDE, 1'b1, "R2 1M masked base");
    endtask

    task automatic t_asid();
        do_load(32'h0400_0000, 8'h11, 22'h0300, 2'b01, 2'b11, 1'b1, 1'b0, 1'b1);
        cur_asid = 8'h22;
        do_acc(32'h0400_0020, 1'b0, 1'b0, F_MISS, 12'h040, 1'b0, 0, 1'b1, "R3 user asid mismatch");
        single_vspace = 1'b1;
        do_acc(32'h0400_0020, 1'b0, 1'b1, F_NONE, 0, 1'b1, 32'h000C_0020, 1'b1, "R3 single space priv skips asid");
        single_vspace = 1'b0;
        do_acc(32'h0400_0020, 1'b0, 1'b1, F_MISS, 12'h040, 1'b0, 0, 1'b1, "R3 priv compares asid");
        cur_asid = 8'h11;
        do_acc(32'h0400_0020, 1'b0, 1'b0, F_NONE, 0, 1'b1, 32'h000C_0020, 1'b1, "R3 user asid match");
        cur_asid = 8'h99;
        do_acc(32'h0040_0ABC, 1'b0, 1'b0, F_NONE, 0, 1'b1, 32'h0080_0ABC, 1'b1, "R3 shared entry");
    endtask

    task automatic t_invalid_multi();
        do_load(32'h0500_0000, 8'h00, 22'h0200, 2'b01, 2'b11, 1'b1, 1'b1, 1'b0);
        do_acc(32'h0500_0004, 1'b0, 1'b1, F_MISS, 12'h040, 1'b0, 0, 1'b1, "R4 invalid entry misses");
        do_load(32'h0600_0000, 8'h00, 22'h0210, 2'b01, 2'b11, 1'b1, 1'b1, 1'b1);
        do_load(32'h0600_0000, 8'h00, 22'h0220, 2'b10, 2'b11, 1'b1, 1'b1, 1'b1);
        do_acc(32'h0600_0010, 1'b0, 1'b1, F_MULTI, 12'h140, 1'b0, 0, 1'b1, "R5 multiple hit");
    endtask

    task automatic t_prot();
        do_load(32'h0700_0000, 8'h00, 22'h0400, 2'b01, 2'b00, 1'b1, 1'b1, 1'b1);
        do_load(32'h0710_0000, 8'h00, 22'h0500, 2'b01, 2'b01, 1'b1, 1'b1, 1'b1);
        do_load(32'h0720_0000, 8'h00, 22'h0600, 2'b01, 2'b10, 1'b1, 1'b1, 1'b1);
        do_acc(32'h0700_0010, 1'b0, 1'b0, F_PROT, 12'h0A0, 1'b1, 0, 1'b1, "R6 p00 user read");
        do_acc(32'h0700_0010, 1'b0, 1'b1, F_NONE, 0, 1'b1, 32'h0010_0010, 1'b1, "R6 p00 priv read");
        do_acc(32'h0700_0010, 1'b1, 1'b1, F_PROT, 12'h0C0, 1'b1, 0, 1'b1, "R6 p00 priv write");
        do_acc(32'h0710_0010, 1'b0, 1'b0, F_PROT, 12'h0A0, 1'b1, 0, 1'b1, "R6 p01 user read");
        do_acc(32'h0710_0010, 1'b1, 1'b1, F_NONE, 0, 1'b1, 32'h0014_0010, 1'b1, "R6 p01 priv write");
        do_acc(32'h0720_0010, 1'b0, 1'b0, F_NONE, 0, 1'b1, 32'h0018_0010, 1'b1, "R6 p10 user read");
        do_acc(32'h0720_0010, 1'b1, 1'b0, F_PROT, 12'h0C0, 1'b1, 0, 1'b1, "R6 p10 user write");
        do_acc(32'h0040_0ABC, 1'b1, 1'b0, F_NONE, 0, 1'b1, 32'h0080_0ABC, 1'b1, "R6 p11 user write");
    endtask

    task automatic t_dirty();
        do_load(32'h0800_0000, 8'h00, 22'h0700, 2'b01, 2'b11, 1'b0, 1'b1, 1'b1);
        do_acc(32'h0800_0010, 1'b1, 1'b1, F_FWR, 12'h080, 1'b1, 0, 1'b1, "R7 first write");
        do_acc(32'h0800_0010, 1'b0, 1'b1, F_NONE, 0, 1'b1, 32'h001C_0010, 1'b1, "R7 clean read");
    endtask

    task automatic t_windows();
        do_acc(32'hA123_4567, 1'b0, 1'b1, F_NONE, 0, 1'b0, 32'h0123_4567, 1'b0, "R8 low window");
        do_acc(32'hF000_0004, 1'b1, 1'b1, F_NONE, 0, 1'b0, 32'hF000_0004, 1'b0, "R8 top window");
        do_acc(32'hE200_0000, 1'b1, 1'b0, F_NONE, 0, 1'b0, 32'hE200_0000, 1'b0, "R8 user allowed range");
        do_acc(32'h8000_0000, 1'b0, 1'b0, F_ADDR, 12'h0E0, 1'b0, 0, 1'b0, "R10 user read error");
        do_acc(32'hE800_0000, 1'b1, 1'b0, F_ADDR, 12'h100, 1'b0, 0, 1'b0, "R10 user write error");
        xlate_en = 1'b0;
        do_acc(32'hC123_4567, 1'b0, 1'b1, F_NONE, 0, 1'b0, 32'h0123_4567, 1'b0, "R9 disabled high");
        do_acc(32'h0040_0ABC, 1'b0, 1'b0, F_NONE, 0, 1'b0, 32'h0040_0ABC, 1'b0, "R9 disabled ignores table");
        xlate_en = 1'b1;
    endtask

    task automatic t_wrap();
        repl_limit = 6'(exp_idx + 1);
        bump("R11 step to boundary");
        bump("R11 wrap at boundary");
        check("R11 counter zero after boundary", 64'(repl_idx), 64'd0);
        repl_limit = 6'd0;
        for (int i = 0; i < 64; i++) bump("R11 full range walk");
        check("R11 wrap past top", 64'(repl_idx), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_sizes();
        t_asid();
        t_invalid_multi();
        t_prot();
        t_dirty();
        t_windows();
        t_wrap();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule